// File: doc/BRIEF.md
# Wide-bus serial flash read controller

This block sits on the host side of a serial flash and performs read transactions over one, two or four data lines. A single-cycle start request supplies a 24-bit byte address, a byte count and a width select. The controller then drives chip select low and generates the serial clock at half the system clock rate, with the clock idling low (SPI mode 0). It shifts out the read opcode on one line, then sends the address on the selected number of lines. In the wide modes it follows the address with a zero mode byte and, for four lines, a short dummy gap. It then turns the bus around and collects the returned bytes, presenting each one on a valid/ready stream.

The four flash data pins are modelled as separate output, output-enable and input vectors. Lines 2 and 3 double as the write-protect and hold pins. Whenever they are not carrying quad data, the controller holds them driven high so that the flash is neither protected nor paused. A four-line read depends on a quad-enable bit that the host keeps cached from the flash's second status register. If that bit is clear, the request is refused with a one-cycle error pulse and the bus is left untouched. When the consumer applies back-pressure, the serial clock pauses in its low phase, so no read data is lost.

Top module: `qspi_rd_ctl`

## Requirements
- R1: The opcode is sent first, most significant bit first, on io line 0 only, one bit per serial clock, with the value stable while the serial clock rises. The opcode is 0xBB for width select 2'b01 (dual), 0xEB for 2'b10 (quad), and 0x03 for 2'b00 or 2'b11 (single).
- R2: After the opcode, the 24 address bits are sent most significant first. Single mode uses one bit per clock on line 0. Dual mode uses two bits per clock on lines 1:0, with line 1 holding the higher bit. Quad mode uses four bits per clock on lines 3:0, with line 3 holding the highest bit.
- R3: In dual and quad modes, a mode byte of 0x00 follows the address on the same lines. Quad mode then adds exactly 4 dummy clocks, with all four output enables released. Dual mode adds no dummy clocks. Single mode sends neither a mode byte nor dummy clocks.
- R4: A start request with the quad width select and qe low produces a single-cycle err pulse. In that case cs_n stays high, sck stays low, and busy stays low.
- R5: Read data is sampled on the rising serial clock edge and packed most significant first. Single mode samples line 1. Dual mode samples lines 1:0. Quad mode samples lines 3:0. Each completed byte appears on rd_data with rd_valid.
- R6: During the data phase, the output enables of lines 0 and 1 are low. Lines 2 and 3 are driven high with their enables set in every phase, except the quad address, dummy and data phases.
- R7: While rd_valid is high and rd_ready is low, rd_valid stays high and rd_data does not change.
- R8: While a byte waits unaccepted, sck does not rise.
- R9: Exactly len bytes are delivered. cs_n returns high only after the last byte is accepted. sck is low whenever cs_n changes, and low while cs_n is high.
- R10: A start with len equal to 0 is ignored. A start while busy is ignored and does not disturb the transaction in progress.
- R11: After reset, cs_n is high, sck is low, busy and rd_valid are low, and io_oe is 4'b1100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle read request |
| addr | input | 24 | Flash byte address |
| len | input | LEN_W | Number of bytes to read |
| width | input | 2 | 01 dual, 10 quad, otherwise single |
| qe | input | 1 | Cached quad-enable status bit |
| busy | output | 1 | Transaction in progress |
| err | output | 1 | Quad request refused pulse |
| sck | output | 1 | Serial clock to the flash |
| cs_n | output | 1 | Active-low chip select |
| io_o | output | 4 | Data line output values |
| io_oe | output | 4 | Data line output enables |
| io_i | input | 4 | Data line input values |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | rd_data holds a byte |
| rd_ready | input | 1 | Consumer accepts the byte |

## Verification
A behavioural flash model captures the opcode, the address bits, the mode byte and the dummy gap at each rising serial clock edge. It answers with address-dependent bytes in the width under test. Running single, dual, quad and the 2'b11 select one after another separates the three opcodes and lane orders: a swapped lane or a wrong shift step corrupts the captured address or the data. An irregular ready pattern and a long ready-low hold check that clock pausing loses and repeats no byte. The refused quad request, the zero-length start and the start issued while busy each show up as a bus that does not move.

// File: rtl/qspi_rd_ctl.sv
module qspi_rd_ctl #(
  parameter int LEN_W  = 16,
  parameter int QDUMMY = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [23:0]      addr,
  input  logic [LEN_W-1:0] len,
  input  logic [1:0]       width,
  input  logic             qe,
  output logic             busy,
  output logic             err,
  output logic             sck,
  output logic             cs_n,
  output logic [3:0]       io_o,
  output logic [3:0]       io_oe,
  input  logic [3:0]       io_i,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic             rd_ready
);
  typedef enum logic [2:0] {S_IDLE, S_CMD, S_ADR, S_DUM, S_DAT, S_END} st_t;

  st_t              st;
  logic [1:0]       md;
  logic [31:0]      sr;
  logic [5:0]       cnt;
  logic [LEN_W-1:0] left;
  logic [7:0]       rx, nxt;

  wire       dual      = md == 2'b01;
  wire       quad      = md == 2'b10;
  wire       req_quad  = width == 2'b10;
  wire [7:0] op        = width == 2'b01 ? 8'hBB : req_quad ? 8'hEB : 8'h03;
  wire [5:0] adr_clks  = quad ? 6'd8 : dual ? 6'd16 : 6'd24;
  wire [5:0] byte_clks = quad ? 6'd2 : dual ? 6'd4 : 6'd8;
  wire       stall     = rd_valid & ~rd_ready;

  assign busy = st != S_IDLE;

  always_comb
    case (md)
      2'b10:   nxt = {rx[3:0], io_i};
      2'b01:   nxt = {rx[5:0], io_i[1:0]};
      default: nxt = {rx[6:0], io_i[1]};
    endcase

  always_comb begin
    io_o  = 4'b1100;
    io_oe = 4'b1100;
    case (st)
      S_CMD: begin
        io_o[0]  = sr[31];
        io_oe[0] = 1'b1;
      end
      S_ADR:
        if (quad) begin
          io_o  = sr[31:28];
          io_oe = 4'hF;
        end else if (dual) begin
          io_o[1:0]  = sr[31:30];
          io_oe[1:0] = 2'b11;
        end else begin
          io_o[0]  = sr[31];
          io_oe[0] = 1'b1;
        end
      S_DUM, S_DAT:
        if (quad) begin
          io_o  = 4'h0;
          io_oe = 4'h0;
        end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= S_IDLE;
      md       <= 2'b00;
      sr       <= '0;
      cnt      <= '0;
      left     <= '0;
      rx       <= '0;
      sck      <= 1'b0;
      cs_n     <= 1'b1;
      err      <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      err <= 1'b0;
      if (rd_valid && rd_ready) rd_valid <= 1'b0;
      case (st)
        S_IDLE:
          if (start) begin
            if (req_quad && !qe) err <= 1'b1;
            else if (len != '0) begin
              md   <= width;
              sr   <= {op, addr};
              cnt  <= 6'd8;
              left <= len;
              cs_n <= 1'b0;
              st   <= S_CMD;
            end
          end
        S_CMD, S_ADR, S_DUM:
          if (!sck) sck <= 1'b1;
          else begin
            sck <= 1'b0;
            cnt <= cnt - 6'd1;
            if (st == S_CMD) sr <= sr << 1;
            else if (st == S_ADR) sr <= quad ? sr << 4 : dual ? sr << 2 : sr << 1;
            if (cnt == 6'd1)
              case (st)
                S_CMD: begin
                  st  <= S_ADR;
                  cnt <= adr_clks;
                end
                S_ADR:
                  if (quad) begin
                    st  <= S_DUM;
                    cnt <= 6'(QDUMMY);
                  end else begin
                    st  <= S_DAT;
                    cnt <= byte_clks;
                  end
                default: begin
                  st  <= S_DAT;
                  cnt <= byte_clks;
                end
              endcase
          end
        S_DAT:
          if (!sck) begin
            if (!stall) begin
              sck <= 1'b1;
              rx  <= nxt;
              if (cnt == 6'd1) begin
                rd_data  <= nxt;
                rd_valid <= 1'b1;
              end
            end
          end else begin
            sck <= 1'b0;
            cnt <= cnt - 6'd1;
            if (cnt == 6'd1) begin
              left <= left - 1'b1;
              cnt  <= byte_clks;
              if (left == 1) st <= S_END;
            end
          end
        S_END:
          if (!rd_valid) begin
            cs_n <= 1'b1;
            st   <= S_IDLE;
          end
        default: st <= S_IDLE;
      endcase
    end

  p_refuse_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> cs_n && !sck && !busy);
  p_refuse_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> cs_n);
  p_idle_clock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  p_pause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall && !sck |=> !sck);
  p_hold_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> rd_valid && $stable(rd_data));
  p_turnaround_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DAT) && $rose(sck) |-> io_oe[1:0] == 2'b00);
  p_zero_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && len == '0 |=> !busy);
endmodule

// File: tb/sim_qspi_rd_ctl.sv
module sim_qspi_rd_ctl;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, qe = 1'b0, rd_ready = 1'b1;
  logic [23:0] addr = '0;
  logic [15:0] len = '0;
  logic [1:0]  width = '0;
  logic [3:0]  io_in = '0;
  logic        busy, err, sck, cs_n, rd_valid;
  logic [3:0]  io_o, io_oe;
  logic [7:0]  rd_data;

  always #4 clk = ~clk;

  qspi_rd_ctl u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .len(len), .width(width), .qe(qe),
    .busy(busy), .err(err), .sck(sck), .cs_n(cs_n), .io_o(io_o), .io_oe(io_oe), .io_i(io_in),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready));

  int checks = 0, errs = 0;
  bit done = 0;
  logic [7:0] q[$];

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  int cur_lanes = 1, edges = 0, dpos = 0, ndum = 0;
  logic [23:0] cur_addr = '0;
  logic [7:0]  cap_op;
  logic [31:0] cap_am;
  bit cmd_bad, adr_bad, dum_bad, dat_bad;

  function automatic logic [7:0] dat(int k);
    return cur_addr[7:0] ^ 8'(k * 59 + 17);
  endfunction

  function automatic int aclk();
    return cur_lanes == 1 ? 24 : 32 / cur_lanes;
  endfunction

  function automatic int pre();
    return 8 + aclk() + (cur_lanes == 4 ? 4 : 0);
  endfunction

  always @(posedge sck) if (!cs_n) begin
    edges++;
    if (edges <= 8) begin
      cap_op = {cap_op[6:0], io_o[0]};
      if (io_oe !== 4'b1101 || io_o[3:2] !== 2'b11) cmd_bad = 1;
    end else if (edges <= 8 + aclk()) begin
      case (cur_lanes)
        4: begin cap_am = {cap_am[27:0], io_o}; if (io_oe !== 4'hF) adr_bad = 1; end
        2: begin cap_am = {cap_am[29:0], io_o[1:0]}; if (io_oe !== 4'b1111 || io_o[3:2] !== 2'b11) adr_bad = 1; end
        default: begin cap_am = {cap_am[30:0], io_o[0]}; if (io_oe !== 4'b1101) adr_bad = 1; end
      endcase
    end else if (edges <= pre()) begin
      ndum++;
      if (io_oe !== 4'h0) dum_bad = 1;
    end else begin
      if (io_oe[1:0] !== 2'b00) dat_bad = 1;
      if (cur_lanes == 4 && io_oe !== 4'h0) dat_bad = 1;
      if (cur_lanes < 4 && (io_oe[3:2] !== 2'b11 || io_o[3:2] !== 2'b11)) dat_bad = 1;
    end
  end

  always @(negedge sck) if (!cs_n && edges >= pre()) begin
    logic [7:0] t;
    t = dat(dpos / 8) << (dpos % 8);
    case (cur_lanes)
      4: io_in = t[7:4];
      2: io_in = {2'b00, t[7:6]};
      default: io_in = {2'b00, t[7], 1'b0};
    endcase
    dpos += cur_lanes;
  end

  int rmode = 0, cyc = 0;
  always @(posedge clk) begin
    #1;
    cyc++;
    rd_ready = rmode == 0 ? 1'b1 : rmode == 2 ? 1'b0 : ((cyc % 5) != 2 && (cyc % 3) != 0);
  end

  bit pstall = 0, psck = 0, pcs = 1;
  logic [7:0] pdata = '0;
  always @(negedge clk) if (rst_n && !done) begin
    if (rd_valid && rd_ready) begin
      if (q.size() == 0) chk(0, "R9", "byte beyond len", rd_data, 0);
      else begin
        logic [7:0] e;
        e = q.pop_front();
        chk(rd_data == e, "R5", "data byte", rd_data, e);
      end
    end
    if (pstall && rd_valid && !rd_ready) begin
      chk(sck == 0, "R8", "sck during pause", sck, 0);
      chk(rd_data == pdata, "R7", "held byte", rd_data, pdata);
    end
    if (cs_n !== pcs) chk(!sck && !psck, "R9", "sck at cs_n change", sck, 0);
    if (cs_n) chk(!sck, "R9", "sck while deselected", sck, 0);
    pstall = rd_valid && !rd_ready;
    pdata  = rd_data;
    pcs    = cs_n;
    psck   = sck;
  end

  task automatic start_read(logic [1:0] w, logic [23:0] a, int n, logic qen);
    cur_lanes = w == 2'b01 ? 2 : w == 2'b10 ? 4 : 1;
    cur_addr = a; edges = 0; dpos = 0; ndum = 0; cap_op = 0; cap_am = 0;
    cmd_bad = 0; adr_bad = 0; dum_bad = 0; dat_bad = 0;
    for (int k = 0; k < n; k++) q.push_back(dat(k));
    @(posedge clk); #1;
    start = 1; addr = a; len = 16'(n); width = w; qe = qen;
    @(posedge clk); #1;
    start = 0;
  endtask

  task automatic finish_read(logic [1:0] w, logic [23:0] a, int n);
    logic [7:0] eop;
    eop = w == 2'b01 ? 8'hBB : w == 2'b10 ? 8'hEB : 8'h03;
    wait (!busy);
    repeat (3) @(posedge clk);
    #1;
    chk(cap_op == eop, "R1", "opcode", cap_op, eop);
    chk(!cmd_bad, "R1", "opcode on line 0 only", cmd_bad, 0);
    if (cur_lanes == 1) chk(cap_am[23:0] == a, "R2", "address", cap_am[23:0], a);
    else begin
      chk(cap_am[31:8] == a, "R2", "address", cap_am[31:8], a);
      chk(cap_am[7:0] == 8'h00, "R3", "mode byte", cap_am[7:0], 0);
    end
    chk(!adr_bad, "R2", "address line enables", adr_bad, 0);
    chk(ndum == (cur_lanes == 4 ? 4 : 0), "R3", "dummy clocks", ndum, cur_lanes == 4 ? 4 : 0);
    chk(!dum_bad, "R3", "dummy enables released", dum_bad, 0);
    chk(!dat_bad, "R6", "data phase enables", dat_bad, 0);
    chk(edges == pre() + n * 8 / cur_lanes, "R9", "total clocks", edges, pre() + n * 8 / cur_lanes);
    chk(q.size() == 0, "R9", "bytes missing", q.size(), 0);
    chk(cs_n == 1, "R9", "cs_n after read", cs_n, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(cs_n == 1 && sck == 0, "R11", "reset cs_n/sck", {cs_n, sck}, 2'b10);
    chk(!busy && !rd_valid, "R11", "reset busy/valid", {busy, rd_valid}, 0);
    chk(io_oe == 4'b1100, "R11", "reset enables", io_oe, 4'b1100);

    start_read(2'b00, 24'h123456, 3, 0);
    finish_read(2'b00, 24'h123456, 3);

    start_read(2'b01, 24'hA5C3F0, 4, 0);
    finish_read(2'b01, 24'hA5C3F0, 4);

    rmode = 1;
    start_read(2'b10, 24'h0F1E2D, 6, 1);
    finish_read(2'b10, 24'h0F1E2D, 6);
    start_read(2'b11, 24'h8001FE, 5, 1);
    finish_read(2'b11, 24'h8001FE, 5);
    rmode = 0;

    @(posedge clk); #1;
    edges = 0; start = 1; width = 2'b10; qe = 0; len = 4; addr = 24'h111111;
    @(posedge clk); #1;
    start = 0;
    chk(err == 1, "R4", "err pulse", err, 1);
    chk(cs_n == 1 && !busy, "R4", "refused cs_n/busy", {cs_n, busy}, 2'b10);
    @(posedge clk); #1;
    chk(err == 0, "R4", "err one cycle", err, 0);
    repeat (10) @(posedge clk);
    #1 chk(edges == 0 && cs_n == 1, "R4", "no bus activity", edges, 0);

    @(posedge clk); #1;
    start = 1; width = 2'b01; len = 0;
    @(posedge clk); #1;
    start = 0;
    chk(!busy && cs_n, "R10", "zero length ignored", busy, 0);

    rmode = 2;
    start_read(2'b01, 24'h3C5A96, 3, 1);
    wait (rd_valid);
    @(negedge clk);
    begin
      int e1;
      logic [7:0] d1;
      e1 = edges; d1 = rd_data;
      repeat (40) @(negedge clk);
      chk(edges == e1, "R8", "clock paused", edges, e1);
      chk(rd_valid && rd_data == d1, "R7", "byte held", rd_data, d1);
    end
    rmode = 0;
    finish_read(2'b01, 24'h3C5A96, 3);

    start_read(2'b00, 24'h654321, 2, 0);
    repeat (6) @(posedge clk);
    #1 start = 1; addr = 24'hFFFFFF; width = 2'b10; qe = 1; len = 9;
    @(posedge clk); #1;
    start = 0;
    finish_read(2'b00, 24'h654321, 2);
    chk(edges == 48, "R10", "busy start ignored", edges, 48);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errs++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end
endmodule